// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Controller

This block supervises one transmit frame of a 10/100 MAC working in half-duplex mode. A byte serializer outside the block sends the frame bits while `tx_active` is high and restarts from the first byte each time `tx_active` rises again. The controller counts bit times on `bit_en`, watches `col` and `crs`, and decides what happens when a collision is seen. If the collision falls inside the protected head of the frame, the controller sends a jam, waits a random backoff and tries again. If it falls after the head, it sends a jam and gives the frame up.

The backoff is a truncated binary exponential one. The random value is taken from a free-running LFSR at the moment of the collision. The random value is masked to a width that grows by one bit with each attempt, up to a cap. After the protected head has gone out cleanly, the controller pulses `buf_release` so the frame buffer can be reused. In 10 Mbps mode it then waits for the heartbeat collision pulse. A one-cycle `frame_done` marks the end of the frame, and the status flags then hold until the next start.

Top module: `hd_tx_collision_ctrl`

## Requirements
- R1: After reset, `tx_active`, `jam_active`, `buf_release` and `frame_done` are low, all status flags are 0 and `st_attempts` is 0.
- R2: A collision seen on a bit time while fewer than CLEAN_BITS bits of the current attempt have gone out starts a jam of JAM_BITS bit times. A backoff of r·SLOT_BITS bit times follows, with 0 ≤ r ≤ 2^min(n,BACKOFF_CAP) − 1 after attempt n. Then `tx_active` rises again for a fresh attempt. Across repeated first collisions, both r = 0 and r = 1 occur.
- R3: A collision seen once CLEAN_BITS bits of the attempt have gone out starts a jam of JAM_BITS bit times. The frame then ends with `st_late` = 1 and is never retransmitted.
- R4: An early collision during attempt MAX_ATTEMPTS starts a jam. The frame then ends with `st_excess` = 1 and `st_attempts` = MAX_ATTEMPTS.
- R5: `buf_release` pulses for one cycle, one cycle after the bit time on which the CLEAN_BITS-th collision-free bit of the attempt went out. It pulses at no other time.
- R6: With `speed10` = 1, held for the whole frame, the controller watches `col` for HB_BITS bit times after `data_end`. A collision in that window ends the frame on the next cycle with `st_no_heartbeat` = 0. With no collision, the frame ends after the full window with `st_no_heartbeat` = 1. With `speed10` = 0, `frame_done` follows `data_end` by one cycle.
- R7: `crs` low on any bit time while `tx_active` is high sets `st_carrier_lost`. `crs` low while idle has no effect.
- R8: `col` has no effect while idle, during the jam and during the backoff.
- R9: `frame_done` is a single-cycle pulse. `start` is ignored while a frame is in progress. The status holds until the next accepted `start`.
- R10: `st_attempts` is 1 when a frame starts and goes up by one on each retransmission. Its value at `frame_done` is the number of attempts made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per bit time |
| speed10 | input | 1 | 1 selects 10 Mbps (heartbeat check on) |
| start | input | 1 | Begin a frame (accepted when idle) |
| data_end | input | 1 | Serializer sent the last frame bit |
| col | input | 1 | Collision indication from the line |
| crs | input | 1 | Carrier sense from the line |
| tx_active | output | 1 | Serializer may send frame bits |
| jam_active | output | 1 | Jam pattern is being sent |
| buf_release | output | 1 | Frame buffer may be overwritten |
| frame_done | output | 1 | Frame handling finished, status valid |
| st_late | output | 1 | Late collision abort |
| st_excess | output | 1 | Attempt limit reached |
| st_no_heartbeat | output | 1 | Heartbeat missing (10 Mbps) |
| st_carrier_lost | output | 1 | Carrier dropped during send |
| st_attempts | output | $clog2(MAX_ATTEMPTS+1) | Attempts made for this frame |

## Verification
With `bit_en` held high, every input is registered once. An input sampled on bit j of an attempt therefore shows at the outputs one cycle later. `buf_release` is checked exactly on the CLEAN_BITS-th observation after `tx_active` rises. `frame_done` is expected one cycle after `data_end` at 100 Mbps. At 10 Mbps it is expected h+1 cycles after the window opens when the heartbeat comes on window cycle h, and HB_BITS cycles after when it never comes. The bench counts the jam and backoff cycles between observations taken on the falling edge. It checks that the jam lasts JAM_BITS cycles, that the backoff is a whole number of slots and that the slot count stays within the bound for the attempt.

// File: rtl/hdcc_pkg.sv
package hdcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_JAM,
        ST_BACKOFF,
        ST_HBWAIT
    } ctl_state_e;

    typedef struct packed {
        logic late;
        logic excess;
        logic no_hb;
        logic crs_lost;
    } frame_flags_t;

    // exponent of the backoff range for a given attempt, truncated at cap
    function automatic int unsigned backoff_exp(int unsigned attempt, int unsigned cap);
        return (attempt < cap) ? attempt : cap;
    endfunction

    // all-ones mask selecting the legal slot range for an attempt
    function automatic logic [31:0] backoff_mask(int unsigned attempt, int unsigned cap);
        return (32'd1 << backoff_exp(attempt, cap)) - 32'd1;
    endfunction

endpackage

// File: rtl/hdcc_prng.sv
module hdcc_prng #(
    parameter int W = 16,
    parameter int OUT_W = 10,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] lfsr_q;

    // Galois form, advances every cycle regardless of activity
    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= W'(1);
        else     lfsr_q <= {1'b0, lfsr_q[W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
    end

    assign rnd = lfsr_q[OUT_W-1:0];

    // R2: generator never locks up in the all-zero state
    a_r2_prng_alive: assert property (@(posedge clk) disable iff (rst) lfsr_q != '0);
endmodule

// File: rtl/hdcc_backoff.sv
module hdcc_backoff
    import hdcc_pkg::*;
#(
    parameter int SLOT_BITS = 512,
    parameter int CAP = 10,
    parameter int ATT_W = 5,
    localparam int SLOT_W = CAP,
    localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              load,
    input  logic [ATT_W-1:0]  attempt,
    input  logic [SLOT_W-1:0] rnd,
    input  logic              run,
    output logic              zero,
    output logic              expire
);
    logic [SLOT_W-1:0] slots_q;
    logic [BIT_W-1:0]  bitc_q;
    logic [SLOT_W-1:0] mask_w;
    logic              slot_end;

    assign mask_w   = SLOT_W'(backoff_mask(32'(attempt), CAP));
    assign slot_end = bitc_q == BIT_W'(SLOT_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            bitc_q  <= '0;
        end else if (load) begin
            slots_q <= rnd & mask_w;
            bitc_q  <= '0;
        end else if (run && bit_en) begin
            if (slot_end) begin
                bitc_q  <= '0;
                slots_q <= slots_q - SLOT_W'(1);
            end else begin
                bitc_q <= bitc_q + BIT_W'(1);
            end
        end
    end

    assign zero   = slots_q == '0;
    assign expire = run && bit_en && slot_end && (slots_q == SLOT_W'(1));

    // R2: the drawn slot count stays inside the range allowed for the attempt
    a_r2_slot_bound: assert property (@(posedge clk) disable iff (rst)
        load |=> slots_q <= $past(mask_w));
    // R2: the waiting state is only ever entered with slots left to wait
    a_r2_run_nonzero: assert property (@(posedge clk) disable iff (rst)
        run |-> slots_q != '0);
endmodule

// File: rtl/hd_tx_collision_ctrl.sv
module hd_tx_collision_ctrl
    import hdcc_pkg::*;
#(
    parameter int CLEAN_BITS   = 512,
    parameter int SLOT_BITS    = 512,
    parameter int JAM_BITS     = 32,
    parameter int HB_BITS      = 40,
    parameter int MAX_ATTEMPTS = 16,
    parameter int BACKOFF_CAP  = 10,
    parameter int LFSR_W       = 16,
    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             speed10,
    input  logic             start,
    input  logic             data_end,
    input  logic             col,
    input  logic             crs,
    output logic             tx_active,
    output logic             jam_active,
    output logic             buf_release,
    output logic             frame_done,
    output logic             st_late,
    output logic             st_excess,
    output logic             st_no_heartbeat,
    output logic             st_carrier_lost,
    output logic [ATT_W-1:0] st_attempts
);
    localparam int BC_W    = $clog2(CLEAN_BITS + 1);
    localparam int CNT_MAX = (JAM_BITS > HB_BITS) ? JAM_BITS : HB_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    ctl_state_e        state;
    frame_flags_t      flags;
    logic [BC_W-1:0]   bitcnt;
    logic [CNT_W-1:0]  cnt;
    logic [ATT_W-1:0]  attempts;
    logic              abort_q;
    logic              release_q;
    logic              done_q;

    logic [BACKOFF_CAP-1:0] rnd;
    logic tick_send, late_now, last_try, bo_load, bo_zero, bo_expire;

    hdcc_prng #(.W(LFSR_W), .OUT_W(BACKOFF_CAP)) u_prng (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    assign tick_send = (state == ST_SEND) && bit_en;
    assign late_now  = bitcnt == BC_W'(CLEAN_BITS);
    assign last_try  = attempts == ATT_W'(MAX_ATTEMPTS);
    assign bo_load   = tick_send && col && !late_now && !last_try;

    hdcc_backoff #(.SLOT_BITS(SLOT_BITS), .CAP(BACKOFF_CAP), .ATT_W(ATT_W)) u_backoff (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .load    (bo_load),
        .attempt (attempts),
        .rnd     (rnd),
        .run     (state == ST_BACKOFF),
        .zero    (bo_zero),
        .expire  (bo_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            flags     <= '0;
            bitcnt    <= '0;
            cnt       <= '0;
            attempts  <= '0;
            abort_q   <= 1'b0;
            release_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            release_q <= 1'b0;
            done_q    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SEND;
                        attempts <= ATT_W'(1);
                        bitcnt   <= '0;
                        flags    <= '0;
                        abort_q  <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (bit_en) begin
                        if (!crs) flags.crs_lost <= 1'b1;
                        if (col) begin
                            state <= ST_JAM;
                            cnt   <= '0;
                            if (late_now) begin
                                flags.late <= 1'b1;
                                abort_q    <= 1'b1;
                            end else if (last_try) begin
                                flags.excess <= 1'b1;
                                abort_q      <= 1'b1;
                            end
                        end else if (data_end) begin
                            if (speed10) begin
                                state <= ST_HBWAIT;
                                cnt   <= '0;
                            end else begin
                                state  <= ST_IDLE;
                                done_q <= 1'b1;
                            end
                        end else if (!late_now) begin
                            bitcnt <= bitcnt + BC_W'(1);
                            if (bitcnt == BC_W'(CLEAN_BITS - 1)) release_q <= 1'b1;
                        end
                    end
                end
                ST_JAM: begin
                    if (bit_en) begin
                        if (cnt == CNT_W'(JAM_BITS - 1)) begin
                            if (abort_q) begin
                                state  <= ST_IDLE;
                                done_q <= 1'b1;
                            end else if (bo_zero) begin
                                state    <= ST_SEND;
                                attempts <= attempts + ATT_W'(1);
                                bitcnt   <= '0;
                            end else begin
                                state <= ST_BACKOFF;
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_BACKOFF: begin
                    if (bo_expire) begin
                        state    <= ST_SEND;
                        attempts <= attempts + ATT_W'(1);
                        bitcnt   <= '0;
                    end
                end
                ST_HBWAIT: begin
                    if (bit_en) begin
                        if (col) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else if (cnt == CNT_W'(HB_BITS - 1)) begin
                            flags.no_hb <= 1'b1;
                            state       <= ST_IDLE;
                            done_q      <= 1'b1;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_active       = state == ST_SEND;
    assign jam_active      = state == ST_JAM;
    assign buf_release     = release_q;
    assign frame_done      = done_q;
    assign st_late         = flags.late;
    assign st_excess       = flags.excess;
    assign st_no_heartbeat = flags.no_hb;
    assign st_carrier_lost = flags.crs_lost;
    assign st_attempts     = attempts;

    // R3: a late-collision jam is never followed by another send
    a_r3_late_no_resend: assert property (@(posedge clk) disable iff (rst)
        (jam_active && st_late) |=> !tx_active);
    // R4: the excess flag only comes with the full attempt count
    a_r4_excess_count: assert property (@(posedge clk) disable iff (rst)
        (frame_done && st_excess) |-> st_attempts == ATT_W'(MAX_ATTEMPTS));
    // R5: buffer release only while the frame keeps sending
    a_r5_release_in_send: assert property (@(posedge clk) disable iff (rst)
        buf_release |-> tx_active);
    // R6: missing heartbeat is only reported in 10 Mbps mode
    a_r6_hb_only_slow: assert property (@(posedge clk) disable iff (rst)
        (frame_done && st_no_heartbeat) |-> speed10);
    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
endmodule

// File: tb/hd_tx_collision_ctrl_bench.sv
module hd_tx_collision_ctrl_bench;
    localparam int CLEAN = 16, SLOT = 4, JAM = 4, HB = 6, MAXA = 5, CAP = 3;
    localparam int AW = $clog2(MAXA + 1);

    logic clk = 1'b0, rst = 1'b1, bit_en = 1'b1, speed10 = 1'b0;
    logic start = 1'b0, data_end = 1'b0, col = 1'b0, crs = 1'b1;
    logic tx_active, jam_active, buf_release, frame_done;
    logic st_late, st_excess, st_no_heartbeat, st_carrier_lost;
    logic [AW-1:0] st_attempts;

    int checks = 0, errors = 0;
    bit seen0 = 0, seen1 = 0, timeout = 0;

    always #10 clk = ~clk;

    hd_tx_collision_ctrl #(.CLEAN_BITS(CLEAN), .SLOT_BITS(SLOT), .JAM_BITS(JAM),
        .HB_BITS(HB), .MAX_ATTEMPTS(MAXA), .BACKOFF_CAP(CAP), .LFSR_W(16)) u_hd_tx_collision_ctrl (
        .clk(clk), .rst(rst), .bit_en(bit_en), .speed10(speed10), .start(start),
        .data_end(data_end), .col(col), .crs(crs), .tx_active(tx_active),
        .jam_active(jam_active), .buf_release(buf_release), .frame_done(frame_done),
        .st_late(st_late), .st_excess(st_excess), .st_no_heartbeat(st_no_heartbeat),
        .st_carrier_lost(st_carrier_lost), .st_attempts(st_attempts));

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic status(bit l, bit e, bit nh, bit cl, int att, string req);
        chk(frame_done == 1'b1, {req, " done"}, frame_done, 1);
        chk(st_late == l, {req, " late"}, st_late, l);
        chk(st_excess == e, {req, " excess"}, st_excess, e);
        chk(st_no_heartbeat == nh, {req, " no_hb"}, st_no_heartbeat, nh);
        chk(st_carrier_lost == cl, {req, " crs"}, st_carrier_lost, cl);
        chk(int'(st_attempts) == att, {req, " attempts"}, st_attempts, att);
    endtask

    task automatic post_done();
        nedge();
        chk(!frame_done, "R9 single-cycle done", frame_done, 0);
        chk(!tx_active && !jam_active, "R9 idle after done", tx_active, 0);
    endtask

    task automatic start_frame();
        start = 1'b1;
        nedge();
        start = 1'b0;
        chk(tx_active, "R10 start accepted", tx_active, 1);
        chk(int'(st_attempts) == 1, "R10 first attempt", st_attempts, 1);
    endtask

    // caller is on the first falling edge of attempt n; collision on bit k
    task automatic collide(int n, int k, bit noisy, output bit ended);
        int jl, gap, r, lim, e;
        bit late, exc;
        for (int j = 0; j <= k; j++) begin
            chk(buf_release == (j == CLEAN), "R5 release timing", buf_release, j == CLEAN);
            if (j == k) col = 1'b1;
            nedge();
        end
        col = 1'b0;
        jl = 0;
        while (jam_active && jl < 1000) begin
            jl++;
            col = noisy;
            nedge();
        end
        chk(jl == JAM, "R2 jam length", jl, JAM);
        gap = 0;
        while (!tx_active && !frame_done && gap < 10000) begin
            gap++;
            col = noisy;
            nedge();
        end
        col = 1'b0;
        late = k >= CLEAN;
        exc  = !late && (n == MAXA);
        ended = late || exc;
        if (ended) begin
            chk(frame_done && gap == 0, late ? "R3 abort after jam" : "R4 abort after jam", gap, 0);
        end else begin
            e = (n < CAP) ? n : CAP;
            lim = (1 << e) - 1;
            r = gap / SLOT;
            chk(tx_active, "R2 retransmit", tx_active, 1);
            chk(gap % SLOT == 0, "R2 whole slots", gap % SLOT, 0);
            chk(r <= lim, "R2 backoff bound", r, lim);
            chk(int'(st_attempts) == n + 1, "R10 attempt count", st_attempts, n + 1);
            if (n == 1 && r == 0) seen0 = 1;
            if (n == 1 && r == 1) seen1 = 1;
        end
    endtask

    // caller is on the first falling edge of an attempt that will complete
    task automatic finish(int len, bit ten, int hb_at, int crs_drop, bit pulse_start);
        int h, exp_h;
        for (int j = 0; j <= len; j++) begin
            chk(buf_release == (j == CLEAN), "R5 release timing", buf_release, j == CLEAN);
            crs = (j != crs_drop);
            start = pulse_start && (j == 1);
            data_end = (j == len);
            nedge();
        end
        data_end = 1'b0;
        crs = 1'b1;
        start = 1'b0;
        h = 0;
        while (!frame_done && h < 100) begin
            col = ten && (h == hb_at);
            nedge();
            col = 1'b0;
            h++;
        end
        exp_h = !ten ? 0 : ((hb_at < HB) ? hb_at + 1 : HB);
        chk(h == exp_h, "R6 done timing", h, exp_h);
    endtask

    task automatic run_all();
        bit ended;
        repeat (3) nedge();
        rst = 1'b0;
        nedge();
        chk(!tx_active && !jam_active && !buf_release && !frame_done, "R1 outputs idle", tx_active, 0);
        chk(!st_late && !st_excess && !st_no_heartbeat && !st_carrier_lost, "R1 flags clear", st_late, 0);
        chk(st_attempts == '0, "R1 attempts", st_attempts, 0);

        // R8 and R7: collision and carrier noise while idle
        col = 1'b1; crs = 1'b0;
        repeat (5) nedge();
        chk(!tx_active && !frame_done && !jam_active, "R8 idle col ignored", tx_active, 0);
        col = 1'b0; crs = 1'b1;

        // R2/R10 sweep over collision counts and positions
        for (int nc = 0; nc < MAXA; nc++) begin
            for (int t = 0; t < 4; t++) begin
                start_frame();
                for (int i = 0; i < nc; i++) collide(i + 1, (t * 5 + i * 3) % CLEAN, t[0], ended);
                finish(CLEAN + 2 + t, 1'b0, 0, -1, 1'b0);
                status(0, 0, 0, 0, nc + 1, "R10 sweep");
                post_done();
                repeat (t + nc) nedge();
            end
        end
        for (int t = 0; t < 24; t++) begin
            start_frame();
            collide(1, t % CLEAN, 1'b1, ended);
            finish(CLEAN + 1, 1'b0, 0, -1, 1'b0);
            status(0, 0, 0, 0, 2, "R2 single retry");
            post_done();
            repeat (t % 7) nedge();
        end
        chk(seen0 && seen1, "R2 both first-retry values", {seen0, seen1}, 3);

        // R3 late collisions
        for (int k = CLEAN; k < CLEAN + 4; k++) begin
            start_frame();
            collide(1, k, 1'b1, ended);
            chk(ended, "R3 late ends frame", ended, 1);
            status(1, 0, 0, 0, 1, "R3 late");
            post_done();
        end
        start_frame();
        collide(1, 2, 1'b0, ended);
        collide(2, CLEAN + 1, 1'b0, ended);
        status(1, 0, 0, 0, 2, "R3 late after retry");
        post_done();

        // R4 excessive collisions
        start_frame();
        for (int n = 1; n <= MAXA; n++) collide(n, n, 1'b1, ended);
        chk(ended, "R4 frame abandoned", ended, 1);
        status(0, 1, 0, 0, MAXA, "R4 excess");
        post_done();

        // R6 heartbeat window sweep at 10 Mbps, then 100 Mbps
        speed10 = 1'b1;
        for (int hb = 0; hb <= HB + 1; hb++) begin
            start_frame();
            finish(20, 1'b1, hb, -1, 1'b0);
            status(0, 0, hb >= HB, 0, 1, "R6 heartbeat");
            post_done();
        end
        speed10 = 1'b0;
        start_frame();
        finish(20, 1'b0, 0, -1, 1'b0);
        status(0, 0, 0, 0, 1, "R6 fast mode no check");
        post_done();

        // R7 carrier loss
        start_frame();
        finish(20, 1'b0, 0, 7, 1'b0);
        status(0, 0, 0, 1, 1, "R7 carrier lost");
        post_done();

        // R9 start ignored while busy
        start_frame();
        collide(1, 3, 1'b0, ended);
        finish(20, 1'b0, 0, 5, 1'b1);
        status(0, 0, 0, 1, 2, "R9 start ignored");
        post_done();
        repeat (3) nedge();
        chk(!tx_active, "R9 no stray frame", tx_active, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule